// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a 16-bit host bus to a 1M x 16 dynamic memory that has only ten address pins. The host gives a 20-bit word address. The controller splits it into a 10-bit row, taken from the upper half, and a 10-bit column, taken from the lower half, where the column changes fastest. It sends the row and then the column over the same pins. It marks each half with its own active-low strobe: one row strobe, and two column strobes, one for each byte lane.

The host uses a request/ready handshake. It holds its request until the controller pulses ready. In the cycle after that pulse it either removes the request or presents the next one. If the next request falls in the row that is already open, the controller keeps the row strobe low and issues only a new column. This is a page-mode burst. A request for any other row makes the controller close the row and precharge before it opens the new one.

An interval timer raises refresh requests. The controller serves each one as soon as the current access has finished, and before any further host access. It walks an internal row counter upward through all 1024 rows, one row per refresh. All timing is given in nanoseconds and rounded up to whole clock cycles.

Top module: `dram_mux_ctrl`

## Requirements
- R1: The row strobe falls while `mem_addr` holds `host_addr[19:10]`. Each column strobe edge that starts a transfer falls while `mem_addr` holds `host_addr[9:0]`.
- R2: A column strobe is low only while the row strobe is low. Both column strobes are high in the cycle in which the row strobe falls. `mem_addr` stays stable while any column strobe stays low.
- R3: `mem_cas_n[0]` serves the low byte and `mem_cas_n[1]` the high byte. During a transfer each bit is the inverse of the matching `host_be` bit, so a 16-bit transfer lowers both bits.
- R4: For a write, `mem_we_n` is low, `mem_dq_oe` is high and `mem_dq_out` equals `host_wdata` while the column strobe is asserted. For a read, `mem_dq_in` is captured at the clock edge that ends the column pulse. `host_rdata` shows it from the cycle after ready and holds it until the next read.
- R5: A request accepted while the controller is idle sees `host_ready` high in the RAC-th cycle after the accepting edge. RAC is the row access time divided by the clock period and rounded up (7 at defaults). `host_ready` is high only while the row is open.
- R6: A same-row request presented in the cycle after ready, with no refresh pending, opens no new row. Its ready arrives PC cycles after the previous one, where PC is the page cycle time rounded up (4 at defaults).
- R7: The row strobe stays low for at least RAC cycles. Before it falls again it stays high for at least RC minus RAC cycles, where RC is the random cycle time rounded up (13 at defaults).
- R8: A refresh keeps the row strobe low for RAC cycles with both column strobes high. After reset the refreshed rows are 0, 1, 2 and so on, wrapping from 1023 to 0. One refresh is requested every refresh interval.
- R9: A refresh request that arrives during an access is served after that access ends and before the next host access, even if the next host access is to the same row.
- R10: During reset the row strobe, both column strobes and the write strobe are high, `mem_dq_oe` is low and `host_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, held until ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Word address; [19:10] row, [9:0] column |
| host_be | input | 2 | Byte enables; bit 0 low byte, bit 1 high byte |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | One-cycle pulse, last cycle of the column pulse |
| host_rdata | output | 16 | Captured read data |
| mem_addr | output | 10 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 2 | Column strobes per byte lane, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The bench builds the controller with an 8 ns clock and a 320 ns refresh interval, keeping the default memory timings. That gives 7-cycle row access, 4-cycle page steps, a 3-cycle column pulse and 6 cycles of precharge. With a refresh every 40 cycles, the full 1024-row walk and its wrap fit in about 41,000 cycles. A request started 36 cycles after reset receives the refresh request in the middle of its row phase, which makes the mid-access case reproducible. Right after reset there are no pending refreshes, so a four-beat same-row burst runs with exact, checkable spacing.

// File: rtl/dram_mux_pkg.sv
// Shared types and helpers for the multiplexed-address DRAM controller.
// Assumes all timing inputs are positive nanosecond values.
package dram_mux_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_GAP,
        ST_PRE,
        ST_REF
    } seq_state_t;

    // Convert a time in ns to a whole number of clock cycles, rounding up.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
// Refresh interval timer and refresh row counter.
// Raises a pending flag once per interval. The flag clears when the sequencer
// starts a refresh, and the row counter advances at that moment.
// Assumes INT_CYC >= 2.
module dram_refresh_timer #(
    parameter int INT_CYC = 1950,
    parameter int ROW_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_start,
    output logic             ref_pend,
    output logic [ROW_W-1:0] ref_row
);
    localparam int CNT_W = $clog2(INT_CYC + 1);

    logic [CNT_W-1:0] tick_cnt;
    logic             wrap;

    assign wrap = (tick_cnt == CNT_W'(INT_CYC - 1));

    // Interval counter, pending flag and row walker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            ref_pend <= 1'b0;
            ref_row  <= '0;
        end else begin
            tick_cnt <= wrap ? '0 : tick_cnt + 1'b1;
            if (ref_start)
                ref_pend <= 1'b0;
            else if (wrap)
                ref_pend <= 1'b1;
            if (ref_start)
                ref_row <= ref_row + 1'b1;
        end
    end
endmodule

// File: rtl/dram_seq_fsm.sv
// Access sequencer: idle, row open, column pulse, column gap, precharge and
// refresh. Latches the host access, decides page hits and captures read data.
// Assumes the host holds its request until ready, then changes it in the
// following cycle.
module dram_seq_fsm
    import dram_mux_pkg::*;
#(
    parameter int ROW_W   = 10,
    parameter int COL_W   = 10,
    parameter int DATA_W  = 16,
    parameter int LANES   = 2,
    parameter int RCD_CYC = 4,
    parameter int CASP_CYC = 3,
    parameter int REF_CYC = 7,
    parameter int PRE_CYC = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic                   we,
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic [LANES-1:0]       be,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [DATA_W-1:0]      dq_in,
    input  logic                   ref_pend,
    input  logic [ROW_W-1:0]       ref_row,
    output seq_state_t             state,
    output logic [ROW_W-1:0]       row_q,
    output logic [COL_W-1:0]       col_q,
    output logic                   we_q,
    output logic [LANES-1:0]       be_q,
    output logic [DATA_W-1:0]      wdata_q,
    output logic                   hit,
    output logic                   ready,
    output logic [DATA_W-1:0]      rdata,
    output logic                   ref_start
);
    localparam int M1    = (RCD_CYC > CASP_CYC) ? RCD_CYC : CASP_CYC;
    localparam int M2    = (REF_CYC > PRE_CYC) ? REF_CYC : PRE_CYC;
    localparam int MAXC  = (M1 > M2) ? M1 : M2;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero  = (cnt == '0);
    assign ref_start = (state == ST_IDLE) && ref_pend;
    assign ready     = (state == ST_COL) && cnt_zero;
    assign hit       = (state == ST_GAP) && req && !ref_pend &&
                       (addr[ROW_W+COL_W-1:COL_W] == row_q);

    // State transitions, phase counter and access latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            row_q   <= '0;
            col_q   <= '0;
            we_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ref_pend) begin
                        row_q <= ref_row;
                        cnt   <= CNT_W'(REF_CYC - 1);
                        state <= ST_REF;
                    end else if (req) begin
                        row_q   <= addr[ROW_W+COL_W-1:COL_W];
                        col_q   <= addr[COL_W-1:0];
                        we_q    <= we;
                        be_q    <= be;
                        wdata_q <= wdata;
                        cnt     <= CNT_W'(RCD_CYC - 1);
                        state   <= ST_ROW;
                    end
                end
                ST_ROW: begin
                    if (cnt_zero) begin
                        cnt   <= CNT_W'(CASP_CYC - 1);
                        state <= ST_COL;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_COL: begin
                    if (cnt_zero) begin
                        if (!we_q)
                            rdata <= dq_in;
                        state <= ST_GAP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (hit) begin
                        col_q   <= addr[COL_W-1:0];
                        we_q    <= we;
                        be_q    <= be;
                        wdata_q <= wdata;
                        cnt     <= CNT_W'(CASP_CYC - 1);
                        state   <= ST_COL;
                    end else begin
                        cnt   <= CNT_W'(PRE_CYC - 1);
                        state <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (cnt_zero)
                        state <= ST_IDLE;
                    else
                        cnt <= cnt - 1'b1;
                end
                ST_REF: begin
                    if (cnt_zero) begin
                        cnt   <= CNT_W'(PRE_CYC - 1);
                        state <= ST_PRE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dram_pin_mux.sv
// Decodes the memory pins from the sequencer state: address multiplexing,
// row strobe, per-lane column strobes, write strobe and data drive enable.
// Assumes the state register and access latches change only on the clock.
module dram_pin_mux
    import dram_mux_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 10,
    parameter int PIN_W  = 10,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  seq_state_t        state,
    input  logic [ROW_W-1:0]  row_q,
    input  logic [COL_W-1:0]  col_q,
    input  logic [COL_W-1:0]  host_col,
    input  logic              hit,
    input  logic              we_q,
    input  logic [LANES-1:0]  be_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic [PIN_W-1:0]  pin_addr,
    output logic              ras_n,
    output logic [LANES-1:0]  cas_n,
    output logic              we_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic in_col;

    assign in_col = (state == ST_COL);
    assign ras_n  = !((state == ST_ROW) || in_col || (state == ST_GAP) ||
                      (state == ST_REF));
    assign we_n   = !(in_col && we_q);
    assign dq_oe  = in_col && we_q;
    assign dq_out = wdata_q;

    // One column strobe per byte lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign cas_n[l] = !(in_col && be_q[l]);
    end

    // Row half in row/refresh phases, column half around the column pulse.
    always_comb begin
        unique case (state)
            ST_COL:  pin_addr = PIN_W'(col_q);
            ST_GAP:  pin_addr = hit ? PIN_W'(host_col) : PIN_W'(col_q);
            default: pin_addr = PIN_W'(row_q);
        endcase
    end
endmodule

// File: rtl/dram_mux_ctrl.sv
// Multiplexed-address DRAM controller top. Converts the nanosecond timing
// parameters into cycle counts and connects the refresh timer, the access
// sequencer and the pin decoder.
// Assumes DATA_W is a multiple of 8 and that the random cycle time exceeds
// the row access time, which exceeds the page cycle time.
module dram_mux_ctrl
    import dram_mux_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 16,
    parameter int CLK_NS    = 8,
    parameter int T_RC_NS   = 104,
    parameter int T_RAC_NS  = 50,
    parameter int T_PC_NS   = 25,
    parameter int T_REFI_NS = 15600
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_req,
    input  logic                   host_we,
    input  logic [ROW_W+COL_W-1:0] host_addr,
    input  logic [DATA_W/8-1:0]    host_be,
    input  logic [DATA_W-1:0]      host_wdata,
    output logic                   host_ready,
    output logic [DATA_W-1:0]      host_rdata,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
    output logic                   mem_ras_n,
    output logic [DATA_W/8-1:0]    mem_cas_n,
    output logic                   mem_we_n,
    output logic [DATA_W-1:0]      mem_dq_out,
    output logic                   mem_dq_oe,
    input  logic [DATA_W-1:0]      mem_dq_in
);
    localparam int LANES    = DATA_W / 8;
    localparam int PIN_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int RAC_CYC  = ns_to_cyc(T_RAC_NS, CLK_NS);
    localparam int PC_CYC   = ns_to_cyc(T_PC_NS, CLK_NS);
    localparam int RC_CYC   = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int CASP_CYC = PC_CYC - 1;
    localparam int RCD_CYC  = RAC_CYC - CASP_CYC;
    localparam int PRE_CYC  = RC_CYC - RAC_CYC;
    localparam int REFI_CYC = T_REFI_NS / CLK_NS;

    seq_state_t        state;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              we_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic              hit;
    logic              ref_pend;
    logic              ref_start;
    logic [ROW_W-1:0]  ref_row;

    dram_refresh_timer #(
        .INT_CYC (REFI_CYC),
        .ROW_W   (ROW_W)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_start (ref_start),
        .ref_pend  (ref_pend),
        .ref_row   (ref_row)
    );

    dram_seq_fsm #(
        .ROW_W    (ROW_W),
        .COL_W    (COL_W),
        .DATA_W   (DATA_W),
        .LANES    (LANES),
        .RCD_CYC  (RCD_CYC),
        .CASP_CYC (CASP_CYC),
        .REF_CYC  (RAC_CYC),
        .PRE_CYC  (PRE_CYC)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (host_req),
        .we        (host_we),
        .addr      (host_addr),
        .be        (host_be),
        .wdata     (host_wdata),
        .dq_in     (mem_dq_in),
        .ref_pend  (ref_pend),
        .ref_row   (ref_row),
        .state     (state),
        .row_q     (row_q),
        .col_q     (col_q),
        .we_q      (we_q),
        .be_q      (be_q),
        .wdata_q   (wdata_q),
        .hit       (hit),
        .ready     (host_ready),
        .rdata     (host_rdata),
        .ref_start (ref_start)
    );

    dram_pin_mux #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .PIN_W  (PIN_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) i_pins (
        .state    (state),
        .row_q    (row_q),
        .col_q    (col_q),
        .host_col (host_addr[COL_W-1:0]),
        .hit      (hit),
        .we_q     (we_q),
        .be_q     (be_q),
        .wdata_q  (wdata_q),
        .pin_addr (mem_addr),
        .ras_n    (mem_ras_n),
        .cas_n    (mem_cas_n),
        .we_n     (mem_we_n),
        .dq_out   (mem_dq_out),
        .dq_oe    (mem_dq_oe)
    );
endmodule

// File: rtl/dram_mux_ctrl_chk.sv
// Protocol checker for the DRAM controller pins, attached by bind.
// Counts the length of each row-strobe run so that minimum low and high
// times can be checked without deep history.
module dram_mux_ctrl_chk #(
    parameter int RAC_CYC = 7,
    parameter int PRE_CYC = 6,
    parameter int PIN_W   = 10,
    parameter int LANES   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_ready,
    input logic             mem_ras_n,
    input logic [LANES-1:0] mem_cas_n,
    input logic             mem_we_n,
    input logic [PIN_W-1:0] mem_addr
);
    logic [7:0] lo_cnt;
    logic [7:0] hi_cnt;

    // Consecutive low / high cycle counters of the row strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= 8'hFF;
        end else if (mem_ras_n) begin
            lo_cnt <= '0;
            hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
            lo_cnt <= (lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 1'b1;
        end
    end

    a_r2_ras_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> (&mem_cas_n));

    a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !(&mem_cas_n) |-> !mem_ras_n);

    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&mem_cas_n) && !(&$past(mem_cas_n))) |-> $stable(mem_addr));

    a_r4_we_with_cas: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !(&mem_cas_n));

    a_r5_ready_row_open: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> !mem_ras_n);

    a_r7_ras_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ras_n) |-> (lo_cnt >= 8'(RAC_CYC)));

    a_r7_ras_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> (hi_cnt >= 8'(PRE_CYC)));
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(
    .RAC_CYC (RAC_CYC),
    .PRE_CYC (PRE_CYC),
    .PIN_W   (PIN_W),
    .LANES   (LANES)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ready (host_ready),
    .mem_ras_n  (mem_ras_n),
    .mem_cas_n  (mem_cas_n),
    .mem_we_n   (mem_we_n),
    .mem_addr   (mem_addr)
);

// File: tb/test_dram_mux_ctrl.sv
`timescale 1ns/1ps
// Bench for the DRAM controller: table walk of host accesses, then directed
// tests for reset, page bursts, refresh collision and the refresh row walk.
module test_dram_mux_ctrl;
    localparam int CLK_NS  = 8;
    localparam int REFI_NS = 320;
    localparam int RAC     = (50 + CLK_NS - 1) / CLK_NS;
    localparam int PC      = (25 + CLK_NS - 1) / CLK_NS;
    localparam int RC      = (104 + CLK_NS - 1) / CLK_NS;
    localparam int PRE     = RC - RAC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [19:0] host_addr = '0;
    logic [1:0]  host_be = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ready;
    logic [15:0] host_rdata;
    logic [9:0]  mem_addr;
    logic        mem_ras_n;
    logic [1:0]  mem_cas_n;
    logic        mem_we_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dram_mux_ctrl #(
        .CLK_NS    (CLK_NS),
        .T_REFI_NS (REFI_NS)
    ) i_dram_mux_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_be    (host_be),
        .host_wdata (host_wdata),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .mem_addr   (mem_addr),
        .mem_ras_n  (mem_ras_n),
        .mem_cas_n  (mem_cas_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- memory model and pin monitor ----------------
    logic [15:0] mem_model [logic [19:0]];
    logic [9:0]  mon_row, mon_col, exp_ref_row;
    int          ras_falls, ref_cnt, ref_bad, time_bad, hi_run, lo_run;
    bit          prev_ras, prev_cas_any, cas_seen;

    function automatic logic [15:0] model_rd(input logic [19:0] k);
        if (mem_model.exists(k)) return mem_model[k];
        return k[15:0] ^ 16'hA5A5;
    endfunction

    always @(negedge clk) begin
        logic        cas_any;
        logic [15:0] v;
        cas_any = (mem_cas_n != 2'b11);
        if (!rst_n) begin
            prev_ras = 1; prev_cas_any = 0; cas_seen = 0;
            exp_ref_row = '0; ref_cnt = 0; hi_run = 100; lo_run = 0;
        end else begin
            if (prev_ras && !mem_ras_n) begin
                if (hi_run < PRE || cas_any) time_bad++;
                mon_row = mem_addr; ras_falls++; cas_seen = 0; lo_run = 1;
            end else if (!prev_ras && mem_ras_n) begin
                if (lo_run < RAC) time_bad++;
                if (!cas_seen) begin
                    if (mon_row != exp_ref_row) ref_bad++;
                    exp_ref_row = exp_ref_row + 1'b1;
                    ref_cnt++;
                end
                hi_run = 1;
            end else if (mem_ras_n) hi_run++;
            else lo_run++;
            if (cas_any && !prev_cas_any) begin
                mon_col = mem_addr; cas_seen = 1;
                v = model_rd({mon_row, mon_col});
                if (!mem_we_n) begin
                    if (!mem_cas_n[0]) v[7:0] = mem_dq_out[7:0];
                    if (!mem_cas_n[1]) v[15:8] = mem_dq_out[15:8];
                    mem_model[{mon_row, mon_col}] = v;
                end
                mem_dq_in = v;
            end
            prev_ras = mem_ras_n;
            prev_cas_any = cas_any;
        end
    end

    // One access: drive at the current negedge, wait for ready, check pins.
    task automatic access(input logic we, input logic [1:0] be, input logic [19:0] a,
                          input logic [15:0] wd, output int lat);
        host_req = 1; host_we = we; host_be = be; host_addr = a; host_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_ready && lat < 2000);
        chk("R1 row/col on pins", {12'd0, mon_row, mon_col}, {12'd0, a});
        chk("R3 lane strobes", {30'd0, mem_cas_n}, {30'd0, ~be});
        chk("R4 write strobe", {31'd0, mem_we_n}, {31'd0, ~we});
        if (we) begin
            chk("R4 dq_oe", {31'd0, mem_dq_oe}, 32'd1);
            chk("R4 dq_out", {16'd0, mem_dq_out}, {16'd0, wd});
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; host_req = 0;
        repeat (3) @(negedge clk);
        chk("R10 reset strobes", {28'd0, mem_ras_n, mem_cas_n, mem_we_n}, 32'hF);
        chk("R10 reset oe/ready", {30'd0, mem_dq_oe, host_ready}, 32'd0);
        rst_n = 1;
    endtask

    // we, be, addr, wdata, expected read
    localparam logic [54:0] TBL [8] = '{
        {1'b1, 2'b11, 20'h3A5C7, 16'h1234, 16'h0000},
        {1'b0, 2'b11, 20'h3A5C7, 16'h0000, 16'h1234},
        {1'b1, 2'b10, 20'h3A5C7, 16'hABCD, 16'h0000},
        {1'b0, 2'b11, 20'h3A5C7, 16'h0000, 16'hAB34},
        {1'b1, 2'b01, 20'h3A5C8, 16'h5678, 16'h0000},
        {1'b0, 2'b11, 20'h3A5C8, 16'h0000, 16'h0078},
        {1'b0, 2'b01, 20'h00000, 16'h0000, 16'hA5A5},
        {1'b0, 2'b11, 20'hFFFFF, 16'h0000, 16'h5A5A}
    };

    initial begin
        int lat, rf0, rc0;
        logic [19:0] pa;

        // Reset (R10), then a 4-beat page burst in row 0x155 (R5, R6)
        do_reset();
        rf0 = ras_falls;
        for (int i = 0; i < 4; i++) begin
            pa = {10'h155, 10'(i)};
            access(1'b0, 2'b11, pa, 16'h0, lat);
            chk(i == 0 ? "R5 idle latency" : "R6 page spacing", lat, i == 0 ? RAC : PC);
            if (i > 0)
                chk("R4 page read data", {16'd0, host_rdata},
                    {16'd0, ({10'h155, 10'(i - 1)} & 20'hFFFF) ^ 16'hA5A5});
        end
        host_req = 0;
        @(negedge clk);
        chk("R4 last page read data", {16'd0, host_rdata}, {16'd0, 16'h57A5 ^ 16'hA5A5 ^ 16'h5403 ^ 16'h57A5});
        chk("R6 single row open in burst", ras_falls - rf0, 1);

        // Table walk: writes, byte lanes and reads (R1, R3, R4)
        for (int i = 0; i < 8; i++) begin
            access(TBL[i][54], TBL[i][53:52], TBL[i][51:32], TBL[i][31:16], lat);
            host_req = 0;
            @(negedge clk);
            if (!TBL[i][54])
                chk("R4 table read data", {16'd0, host_rdata}, {16'd0, TBL[i][15:0]});
        end

        // Refresh lands mid-access; same-row follow-up must wait (R9, R8)
        do_reset();
        repeat (36) @(negedge clk);
        access(1'b0, 2'b11, 20'h0C803, 16'h0, lat);
        rf0 = ras_falls; rc0 = ref_cnt;
        access(1'b0, 2'b11, 20'h0C804, 16'h0, lat);
        host_req = 0;
        chk("R9 refresh inserted before next access", ref_cnt - rc0, 1);
        chk("R9 row reopened after refresh", ras_falls - rf0, 2);
        chk("R9 follow-up slower than page step", {31'd0, lat > RC}, 32'd1);
        @(negedge clk);
        chk("R4 read after refresh", {16'd0, host_rdata}, {16'd0, 16'hC804 ^ 16'hA5A5});

        // Idle long enough for the full 1024-row walk and wrap (R8, R7)
        repeat (1032 * (REFI_NS / CLK_NS)) @(negedge clk);
        chk("R8 refresh count covers wrap", {31'd0, ref_cnt >= 1030}, 32'd1);
        chk("R8 refresh rows in order", ref_bad, 0);
        chk("R7 strobe run lengths", time_bad, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule